// File: doc/BRIEF.md
# Pipelined burst SRAM command front-end

This block models a synchronous SRAM with a register-to-register read pipeline and four-beat bursts. Each rising edge is classified as one command from two start strobes, a burst-advance input, three chip enables and the write-enable inputs. The address is registered on the edge that takes the command, and read data for that address sits in the output register after the following edge. Words are 18 bits wide and split into two 9-bit lanes. The array holds 2^ADDR_W words.

The decoder has two states. `ST_IDLE` means deselected and `ST_BURST` means a burst is open. Each edge takes exactly one command:
- `CMD_START_P` is a processor-strobe start. It always reads and moves the decoder to `ST_BURST`.
- `CMD_START_C` is a controller-strobe start. It reads or writes and moves the decoder to `ST_BURST`.
- `CMD_DESEL` moves the decoder from either state to `ST_IDLE`.
- `CMD_HOLD` is a processor strobe blocked by the master enable. Nothing happens and the state stays as it was.
- `CMD_CONT` is a beat in `ST_BURST`. The state stays `ST_BURST`.
- `CMD_NONE` is an edge in `ST_IDLE` with both strobes high. The state stays `ST_IDLE`.

The output enable is combinational. It is gated by a pipelined flag showing that the edge before last was a selected read. A write on the last edge forces the enable low.

Top module: `bsram_burst_top`

## Requirements
- R1: While reset is asserted, and after it is released until a read has passed the pipeline, `dout_en` is 0.
- R2: An edge with `cpu_strb_n` low, `en_main_n` low, `en_aux` high and `en_aux_n` low starts a read of `addr`. This holds whatever `ctl_strb_n`, `adv_n`, `wr_all_n`, `wr_byte_n` and `lane_wr_n` are. The word is on `dout` from the second rising edge onward.
- R3: An edge with `cpu_strb_n` low and `en_main_n` high does nothing. It performs no read and no write, leaves the burst state and beat unchanged, and ignores `ctl_strb_n`.
- R4: A controller start takes an edge with `ctl_strb_n` low, `cpu_strb_n` high and all three enables active. It writes `din` to `addr` when the lane decode (R5) is nonzero and otherwise starts a read of `addr`.
- R5: The lane decode works as follows. If `wr_all_n` is low, both lanes are written. Otherwise, if `wr_byte_n` is low, lane i is written when `lane_wr_n[i]` is low; lane 0 is bits 8:0 and lane 1 is bits 17:9. Otherwise no lane is written.
- R6: Each later edge of an open burst with both strobes high is a beat. The beat counter advances by one (mod 4) when `adv_n` is low and stays put when it is high. The beat writes `din` to the beat address when the lane decode is nonzero, and otherwise reads the beat address.
- R7: The beat address keeps the upper address bits of the start address. Its low two bits are start+beat mod 4 when `seq_linear` is 1, and start XOR beat when it is 0.
- R8: `dout_en` is 1 only while `oe_n` is low. It requires that the edge before last performed a read and that the last edge performed no write.
- R9: An edge that performs a write holds `dout_en` low for the following cycle, even when the output register holds read data from the edge before.
- R10: Several edges deselect the device: a processor strobe with the master enable active but another enable inactive, or a controller strobe (processor strobe high) with any enable inactive. `dout_en` is then 0 after the second edge. Edges in the deselected state with both strobes high write nothing.
- R11: `adv_n` is ignored on a start edge. The first beat always uses the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address taken on start edges |
| cpu_strb_n | input | 1 | Processor start strobe, active low |
| ctl_strb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_main_n | input | 1 | Master chip enable, active low |
| en_aux | input | 1 | Second chip enable, active high |
| en_aux_n | input | 1 | Third chip enable, active low |
| seq_linear | input | 1 | Beat order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, combinational |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_byte_n | input | 1 | Enables the per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Output register contents |
| dout_en | output | 1 | Drive enable for the data output |

## Verification
A wrong beat counter or start address shows as a wrong word on `dout` two edges after the faulty beat. A stale or missing write shows the same way on the first later read of that address. A decoder stuck in `ST_BURST` after a deselect, or a lost write flag, shows as `dout_en` high one cycle too long or in the wrong cycle. The bench compares enable and data in every cycle against a reference model, so any such fault surfaces within two edges of the access that exposes it.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_HOLD,
        CMD_START_P,
        CMD_START_C,
        CMD_DESEL,
        CMD_CONT
    } cmd_e;
endpackage

// File: rtl/bsram_beat_addr.sv
module bsram_beat_addr #(
    parameter int ADDR_W = 6,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              linear,
    output logic [ADDR_W-1:0] addr
);
    logic [BEAT_W-1:0] low;

    assign low = linear ? (base[BEAT_W-1:0] + beat) : (base[BEAT_W-1:0] ^ beat);

    generate
        if (ADDR_W > BEAT_W) begin : g_wide
            assign addr = {base[ADDR_W-1:BEAT_W], low};
        end else begin : g_narrow
            assign addr = low;
        end
    endgenerate
endmodule

// File: rtl/bsram_lane_dec.sv
module bsram_lane_dec #(
    parameter int LANES = 2
) (
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lanes
);
    always_comb begin
        if (!wr_all_n) begin
            lanes = '1;
        end else if (!wr_byte_n) begin
            lanes = ~lane_wr_n;
        end else begin
            lanes = '0;
        end
    end
endmodule

// File: rtl/bsram_cmd_fsm.sv
module bsram_cmd_fsm
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              adv_n,
    input  logic              en_main_n,
    input  logic              en_aux,
    input  logic              en_aux_n,
    input  logic              seq_linear,
    input  logic [LANES-1:0]  lanes,
    output state_e            state_q,
    output op_e               op_q,
    output logic [ADDR_W-1:0] op_addr_q,
    output logic [LANES-1:0]  op_lanes_q
);
    cmd_e              cmd;
    state_e            state_d;
    op_e               op_d;
    logic [ADDR_W-1:0] base_q, base_d, op_addr_d;
    logic [BEAT_W-1:0] beat_q, beat_d, beat_step;
    logic [LANES-1:0]  op_lanes_d;
    logic [ADDR_W-1:0] beat_addr;
    logic              all_on;
    logic              any_lane;

    assign all_on    = !en_main_n && en_aux && !en_aux_n;
    assign any_lane  = |lanes;
    assign beat_step = adv_n ? beat_q : beat_q + 1'b1;

    bsram_beat_addr #(
        .ADDR_W(ADDR_W),
        .BEAT_W(BEAT_W)
    ) u_beat (
        .base  (base_q),
        .beat  (beat_step),
        .linear(seq_linear),
        .addr  (beat_addr)
    );

    // edge classification
    always_comb begin
        if (!cpu_strb_n) begin
            if (en_main_n) begin
                cmd = CMD_HOLD;
            end else if (all_on) begin
                cmd = CMD_START_P;
            end else begin
                cmd = CMD_DESEL;
            end
        end else if (!ctl_strb_n) begin
            cmd = all_on ? CMD_START_C : CMD_DESEL;
        end else begin
            unique case (state_q)
                ST_IDLE:  cmd = CMD_NONE;
                ST_BURST: cmd = CMD_CONT;
                default:  cmd = CMD_NONE;
            endcase
        end
    end

    // next state and registered operation
    always_comb begin
        state_d    = state_q;
        base_d     = base_q;
        beat_d     = beat_q;
        op_d       = OP_NONE;
        op_addr_d  = op_addr_q;
        op_lanes_d = '0;
        unique case (cmd)
            CMD_NONE, CMD_HOLD: begin
            end
            CMD_START_P: begin
                state_d   = ST_BURST;
                base_d    = addr;
                beat_d    = '0;
                op_d      = OP_READ;
                op_addr_d = addr;
            end
            CMD_START_C: begin
                state_d    = ST_BURST;
                base_d     = addr;
                beat_d     = '0;
                op_d       = any_lane ? OP_WRITE : OP_READ;
                op_addr_d  = addr;
                op_lanes_d = lanes;
            end
            CMD_DESEL: begin
                state_d = ST_IDLE;
            end
            CMD_CONT: begin
                beat_d     = beat_step;
                op_d       = any_lane ? OP_WRITE : OP_READ;
                op_addr_d  = beat_addr;
                op_lanes_d = lanes;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            beat_q     <= '0;
            op_q       <= OP_NONE;
            op_addr_q  <= '0;
            op_lanes_q <= '0;
        end else begin
            state_q    <= state_d;
            base_q     <= base_d;
            beat_q     <= beat_d;
            op_q       <= op_d;
            op_addr_q  <= op_addr_d;
            op_lanes_q <= op_lanes_d;
        end
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  op_e                     op,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic [LANES-1:0]        op_lanes,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout_q,
    output logic                    rd_flag
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANES*LANE_W-1:0] din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q   <= '0;
            rd_flag <= 1'b0;
        end else begin
            din_q   <= din;
            rd_flag <= (op == OP_READ);
        end
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [LANE_W-1:0] cells [DEPTH];
            logic [LANE_W-1:0] lane_q;

            always_ff @(posedge clk) begin
                if (op == OP_WRITE && op_lanes[l]) begin
                    cells[op_addr] <= din_q[l*LANE_W +: LANE_W];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (op == OP_READ) begin
                    lane_q <= cells[op_addr];
                end
            end

            assign dout_q[l*LANE_W +: LANE_W] = lane_q;
        end
    endgenerate
endmodule

// File: rtl/bsram_burst_top.sv
module bsram_burst_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    cpu_strb_n,
    input  logic                    ctl_strb_n,
    input  logic                    adv_n,
    input  logic                    en_main_n,
    input  logic                    en_aux,
    input  logic                    en_aux_n,
    input  logic                    seq_linear,
    input  logic                    oe_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int BEAT_W = 2;

    logic [LANES-1:0]  lanes;
    state_e            state_w;
    op_e               op_w;
    logic [ADDR_W-1:0] op_addr_w;
    logic [LANES-1:0]  lanes_w;
    logic              rd_flag;

    bsram_lane_dec #(.LANES(LANES)) u_lane (
        .wr_all_n (wr_all_n),
        .wr_byte_n(wr_byte_n),
        .lane_wr_n(lane_wr_n),
        .lanes    (lanes)
    );

    bsram_cmd_fsm #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .BEAT_W(BEAT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .cpu_strb_n(cpu_strb_n),
        .ctl_strb_n(ctl_strb_n),
        .adv_n     (adv_n),
        .en_main_n (en_main_n),
        .en_aux    (en_aux),
        .en_aux_n  (en_aux_n),
        .seq_linear(seq_linear),
        .lanes     (lanes),
        .state_q   (state_w),
        .op_q      (op_w),
        .op_addr_q (op_addr_w),
        .op_lanes_q(lanes_w)
    );

    bsram_array #(
        .ADDR_W(ADDR_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_w),
        .op_addr (op_addr_w),
        .op_lanes(lanes_w),
        .din     (din),
        .dout_q  (dout),
        .rd_flag (rd_flag)
    );

    assign dout_en = rd_flag && !oe_n && (op_w != OP_WRITE);
endmodule

// File: rtl/bsram_burst_chk.sv
module bsram_burst_chk
    import bsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_strb_n,
    input logic             ctl_strb_n,
    input logic             en_main_n,
    input logic             en_aux,
    input logic             en_aux_n,
    input logic             oe_n,
    input logic             wr_all_n,
    input logic             dout_en,
    input state_e           state_w,
    input op_e              op_w,
    input logic [LANES-1:0] lanes_w
);
    logic all_on, desel, gw_edge;

    assign all_on  = !en_main_n && en_aux && !en_aux_n;
    assign desel   = (!cpu_strb_n && !en_main_n && !(en_aux && !en_aux_n))
                  || (cpu_strb_n && !ctl_strb_n && !all_on);
    assign gw_edge = cpu_strb_n && !wr_all_n
                  && ((!ctl_strb_n && all_on) || (ctl_strb_n && state_w == ST_BURST));

    p_out_needs_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !oe_n);

    p_cpu_never_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strb_n |=> op_w != OP_WRITE);

    p_main_blocks_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n && en_main_n) |=> (op_w == OP_NONE && state_w == $past(state_w)));

    p_global_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gw_edge |=> (op_w == OP_WRITE && lanes_w == {LANES{1'b1}}));

    p_write_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gw_edge |=> !dout_en);

    p_desel_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> state_w == ST_IDLE);

    p_desel_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> ##1 !dout_en);
endmodule

bind bsram_burst_top bsram_burst_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_strb_n(cpu_strb_n),
    .ctl_strb_n(ctl_strb_n),
    .en_main_n (en_main_n),
    .en_aux    (en_aux),
    .en_aux_n  (en_aux_n),
    .oe_n      (oe_n),
    .wr_all_n  (wr_all_n),
    .dout_en   (dout_en),
    .state_w   (state_w),
    .op_w      (op_w),
    .lanes_w   (lanes_w)
);

// File: tb/bsram_burst_top_tb_top.sv
`timescale 1ns/1ps
module bsram_burst_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
    logic        main_n = 1'b0, aux = 1'b1, aux_n = 1'b0, lin = 1'b1;
    logic        oe_n = 1'b0, gw_n = 1'b1, bwe_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [17:0] mem_m [64];
    bit          m_state = 0;
    logic [5:0]  m_base = '0, m_addr = '0;
    logic [1:0]  m_beat = '0, m_op = '0, m_lanes = '0;
    logic [17:0] m_din = '0, m_dout = '0;
    bit          m_rd = 0;

    always #5 clk = ~clk;

    bsram_burst_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_strb_n(cpu_n), .ctl_strb_n(ctl_n),
        .adv_n(adv_n), .en_main_n(main_n), .en_aux(aux), .en_aux_n(aux_n),
        .seq_linear(lin), .oe_n(oe_n), .wr_all_n(gw_n), .wr_byte_n(bwe_n),
        .lane_wr_n(bw_n), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [5:0] beat_addr(logic [5:0] b, logic [1:0] k, logic l);
        logic [1:0] lo;
        lo = l ? (b[1:0] + k) : (b[1:0] ^ k);
        return {b[5:2], lo};
    endfunction

    function automatic logic [1:0] lane_dec();
        if (!gw_n) return 2'b11;
        if (!bwe_n) return ~bw_n;
        return 2'b00;
    endfunction

    task automatic model_edge();
        logic [1:0] ln;
        bit on;
        if (m_op == 2'd1) begin m_dout = mem_m[m_addr]; m_rd = 1; end
        else m_rd = 0;
        if (m_op == 2'd2) begin
            if (m_lanes[0]) mem_m[m_addr][8:0]  = m_din[8:0];
            if (m_lanes[1]) mem_m[m_addr][17:9] = m_din[17:9];
        end
        m_din = din;
        ln = lane_dec();
        on = !main_n && aux && !aux_n;
        m_op = 2'd0;
        if (!cpu_n) begin
            if (!main_n) begin
                if (on) begin
                    m_state = 1; m_base = addr; m_beat = 0; m_op = 2'd1; m_addr = addr;
                end else m_state = 0;
            end
        end else if (!ctl_n) begin
            if (on) begin
                m_state = 1; m_base = addr; m_beat = 0; m_addr = addr;
                m_op = (ln != 0) ? 2'd2 : 2'd1; m_lanes = ln;
            end else m_state = 0;
        end else if (m_state) begin
            if (!adv_n) m_beat = m_beat + 1'b1;
            m_addr = beat_addr(m_base, m_beat, lin);
            m_op = (ln != 0) ? 2'd2 : 2'd1; m_lanes = ln;
        end
    endtask

    task automatic chk(bit ok, string tag, string what, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        bit exp_en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_en = m_rd && !oe_n && (m_op != 2'd2);
        chk(dout_en == exp_en, tag, "dout_en", {17'd0, dout_en}, {17'd0, exp_en});
        if (exp_en) chk(dout == m_dout, tag, "dout", dout, m_dout);
    endtask

    task automatic quiet();
        cpu_n = 1; ctl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
        main_n = 0; aux = 1; aux_n = 0;
    endtask

    task automatic cpu_read(logic [5:0] a, string tag);
        quiet(); cpu_n = 0; addr = a; step(tag); cpu_n = 1;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(dout_en == 1'b0, "R1", "dout_en in reset", {17'd0, dout_en}, 18'd0);
        rst_n = 1;
        step("R1");

        // fill the array with linear bursts from the controller strobe
        lin = 1;
        for (int b = 0; b < 64; b += 4) begin
            quiet(); ctl_n = 0; gw_n = 0; addr = b[5:0]; din = 18'($urandom);
            step("R4");
            ctl_n = 1;
            for (int k = 0; k < 3; k++) begin
                adv_n = 0; din = 18'($urandom); step("R6");
            end
        end
        quiet(); step("R6");
        cpu_read(6'd0, "R6"); quiet(); ctl_n = 0; aux = 0; step("R10");

        // processor read ignores write enables and controller strobe
        quiet(); cpu_n = 0; ctl_n = 0; gw_n = 0; bwe_n = 0; bw_n = 2'b00; adv_n = 0; addr = 6'd5;
        step("R2"); quiet(); step("R11"); step("R2"); step("R2");

        // interleaved burst order
        lin = 0; cpu_read(6'd6, "R7");
        for (int k = 0; k < 4; k++) begin adv_n = 0; step("R7"); end
        lin = 1; cpu_read(6'd13, "R7");
        for (int k = 0; k < 4; k++) begin adv_n = 0; step("R7"); end

        // lane writes then read back
        quiet(); ctl_n = 0; bwe_n = 0; bw_n = 2'b10; addr = 6'd20; din = 18'h2a5a5;
        step("R5"); quiet(); ctl_n = 0; bwe_n = 0; bw_n = 2'b01; addr = 6'd21; din = 18'h15a5a;
        step("R5"); quiet(); ctl_n = 0; bwe_n = 1; bw_n = 2'b00; addr = 6'd22; din = 18'h3ffff;
        step("R5");
        cpu_read(6'd20, "R5"); cpu_read(6'd21, "R5"); cpu_read(6'd22, "R5"); quiet(); step("R5");

        // blocked processor strobe during a burst
        cpu_read(6'd33, "R3");
        quiet(); cpu_n = 0; main_n = 1; ctl_n = 0; gw_n = 0; step("R3");
        quiet(); adv_n = 0; step("R3"); step("R3");

        // write right after a read hides the output
        cpu_read(6'd40, "R9"); quiet(); step("R9");
        gw_n = 0; din = 18'h01234; step("R9"); quiet(); step("R9"); step("R9");

        // output enable high
        oe_n = 1; cpu_read(6'd41, "R8"); quiet(); step("R8"); oe_n = 0; step("R8");

        // deselect, then idle edges with writes
        quiet(); cpu_n = 0; aux_n = 1; step("R10");
        quiet(); gw_n = 0; din = 18'h0beef; step("R10"); step("R10");
        cpu_read(6'd41, "R10"); quiet(); step("R10"); step("R10");

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 16);
            cpu_n  = (r == 0) ? 1'b0 : 1'b1;
            ctl_n  = (r == 1 || r == 2) ? 1'b0 : 1'b1;
            adv_n  = 1'($urandom % 2);
            main_n = ($urandom % 10 == 0);
            aux    = ($urandom % 10 != 0);
            aux_n  = ($urandom % 10 == 0);
            gw_n   = ($urandom % 4 != 0);
            bwe_n  = 1'($urandom % 2);
            bw_n   = 2'($urandom);
            oe_n   = ($urandom % 6 == 0);
            if ($urandom % 50 == 0) lin = ~lin;
            din    = 18'($urandom);
            addr   = 6'($urandom);
            step("R6");
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule